// File: doc/BRIEF.md
# Fractional Clock Divider with Duty-Cycle Stretching

This block produces a slower clock from a fast base clock. The ratio is a fraction N/M with N no larger than M. An accumulator register adds N on every base cycle. Whenever the running sum reaches M, the accumulator subtracts M and a tick occurs. Over a long stretch of time there are therefore exactly N ticks for every M base cycles. Each tick gives a one-cycle pulse on `div_en`, which downstream flops use as a clock enable. `div_clk` is a registered clock level intended for the output clocks of one subdomain. Every consumer in that subdomain takes the same divider, so they all run at one frequency.

When stretching is off, `div_clk` is high for exactly one base cycle per tick. When stretching is on, `div_clk` rises at a tick and falls once the accumulator has climbed past half of M, which gives the nearest achievable 50% split. New N, M and stretch values go into a shadow register. They reach the divider only at the next tick, or at the next edge while the divider is stopped, so a change never cuts a phase short. A bypass input hands the base clock straight to the subdomain and holds the enable high.

The controller is a state machine with three states. `FCD_IDLE` means stopped, with outputs low and the accumulator at zero. `FCD_LOW` means counting with the output low. `FCD_HIGH` means the output is high. The transitions are:
- IDLE to LOW when the run enable is set and N is non-zero.
- LOW to HIGH on a tick.
- HIGH to HIGH on a further tick.
- HIGH to LOW on the first non-tick cycle when stretching is off. With stretching on, HIGH to LOW on the first non-tick cycle whose updated accumulator is at least ceil(M/2).
- LOW or HIGH to IDLE when the run enable drops or N is zero.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, `div_en` and `div_clk` are 0 and stay 0 while `cfg_run` is 0 and `cfg_bypass` is 0.
- R2: `cfg_run` is sampled high at edge E0, and the accumulator starts at 0 in the following cycle. The j-th tick then falls t_j = ceil(j*M/N)-1 cycles into the count, and `div_en` is high for exactly one cycle in the cycle after each tick.
- R3: Over a 700-cycle window at N/M = 3/7, the number of `div_en` pulses is 300 plus or minus 1.
- R4: With N equal to M, `div_en` is high on every cycle once the divider is counting.
- R5: With N = 0, or with `cfg_run` low, `div_en` and `div_clk` are low. After `cfg_run` falls, both are low from the next edge on.
- R6: With stretching off, `div_clk` equals `div_en` on every cycle.
- R7: With stretching on, `div_clk` rises together with `div_en`. It falls on the first non-tick cycle whose updated accumulator is at least ceil(M/2). At 1/8 this gives 4 cycles high and 4 low; at 1/5 it gives 3 high and 2 low.
- R8: A write (`cfg_we` high for one cycle) made while counting leaves the current interval unchanged. The new values take effect at the next tick, and the accumulator restarts from 0 at that point. A write made while stopped applies at the next edge.
- R9: A written numerator larger than the denominator is clamped to the denominator.
- R10: With `cfg_bypass` high, `div_en` is held at 1 and `div_clk` follows the base clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for numerator, denominator and stretch |
| cfg_num | input | W | Numerator N |
| cfg_den | input | W | Denominator M |
| cfg_stretch | input | 1 | 1 selects near-50% duty output |
| cfg_run | input | 1 | Run enable, level |
| cfg_bypass | input | 1 | 1 passes the base clock through |
| div_en | output | 1 | One-cycle enable pulse per tick |
| div_clk | output | 1 | Divided clock level |

## Verification
A wrong accumulator value shows up at the ports as a shifted pulse. The gap between two `div_en` pulses is then wrong by at least one cycle, and this appears at the very next tick, within M cycles. A stuck or wrongly entered state shows up within one cycle as a difference between `div_clk` and `div_en` when stretching is off. With stretching on, it shows as a wrong high-phase length in the first period. A shadow register that loads at the wrong moment shows up as an interval of the wrong length right after a write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        FCD_IDLE = 2'd0,
        FCD_LOW  = 2'd1,
        FCD_HIGH = 2'd2
    } fcd_state_e;
endpackage

// File: rtl/fcd_cfg_shadow.sv
module fcd_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         stretch_i,
    input  logic         load_i,
    output logic [W-1:0] num_o,
    output logic [W-1:0] den_o,
    output logic         stretch_o,
    output logic         applied_o
);
    logic [W-1:0] num_clamped;
    logic [W-1:0] pend_num, pend_den;
    logic         pend_stretch, pend_valid;

    // Clamp the numerator so that the ratio never exceeds one.
    assign num_clamped = (num_i > den_i) ? den_i : num_i;
    assign applied_o   = load_i && (wr_i || pend_valid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_num     <= '0;
            pend_den     <= '0;
            pend_stretch <= 1'b0;
            pend_valid   <= 1'b0;
            num_o        <= '0;
            den_o        <= '0;
            stretch_o    <= 1'b0;
        end else begin
            if (wr_i) begin
                pend_num     <= num_clamped;
                pend_den     <= den_i;
                pend_stretch <= stretch_i;
                pend_valid   <= 1'b1;
            end
            if (load_i) begin
                if (wr_i) begin
                    num_o      <= num_clamped;
                    den_o      <= den_i;
                    stretch_o  <= stretch_i;
                    pend_valid <= 1'b0;
                end else if (pend_valid) begin
                    num_o      <= pend_num;
                    den_o      <= pend_den;
                    stretch_o  <= pend_stretch;
                    pend_valid <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fcd_phase_acc.sv
module fcd_phase_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running_i,
    input  logic         clear_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         tick_o,
    output logic [W:0]   acc_o,
    output logic [W:0]   acc_nx_o
);
    localparam int AW = W + 1;

    logic [AW-1:0] sum;

    assign sum    = acc_o + AW'(num_i);
    assign tick_o = running_i && (sum >= AW'(den_i));

    always_comb begin
        if (!running_i)  acc_nx_o = '0;
        else if (tick_o) acc_nx_o = sum - AW'(den_i);
        else             acc_nx_o = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_o <= '0;
        else if (clear_i) acc_o <= '0;
        else              acc_o <= acc_nx_o;
    end
endmodule

// File: rtl/fcd_shape_fsm.sv
module fcd_shape_fsm #(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go_i,
    input  logic                   tick_i,
    input  logic                   stretch_i,
    input  logic [W:0]             acc_nx_i,
    input  logic [W:0]             half_i,
    output fcd_pkg::fcd_state_e    state_o,
    output logic                   clk_o,
    output logic                   en_o
);
    import fcd_pkg::*;

    fcd_state_e state_nx;

    always_comb begin
        state_nx = state_o;
        unique case (state_o)
            FCD_IDLE: begin
                if (go_i) state_nx = FCD_LOW;
            end
            FCD_LOW: begin
                if (!go_i)       state_nx = FCD_IDLE;
                else if (tick_i) state_nx = FCD_HIGH;
            end
            FCD_HIGH: begin
                if (!go_i)                     state_nx = FCD_IDLE;
                else if (tick_i)               state_nx = FCD_HIGH;
                else if (!stretch_i)           state_nx = FCD_LOW;
                else if (acc_nx_i >= half_i)   state_nx = FCD_LOW;
            end
            default: state_nx = FCD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= FCD_IDLE;
        else        state_o <= state_nx;
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_o <= 1'b0;
            en_o  <= 1'b0;
        end else begin
            clk_o <= (state_nx == FCD_HIGH);
            en_o  <= tick_i;
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_num,
    input  logic [W-1:0] cfg_den,
    input  logic         cfg_stretch,
    input  logic         cfg_run,
    input  logic         cfg_bypass,
    output logic         div_en,
    output logic         div_clk
);
    import fcd_pkg::*;
    localparam int AW = W + 1;

    fcd_state_e    state_q;
    logic [W-1:0]  act_num, act_den;
    logic          act_stretch;
    logic          applied, tick, go, running, load;
    logic [AW-1:0] acc_q, acc_nx, half;
    logic          clk_q, en_q;

    assign go      = cfg_run && (act_num != '0);
    assign running = go && (state_q != FCD_IDLE);
    assign load    = tick || (state_q == FCD_IDLE);
    assign half    = (AW'(act_den) + AW'(1)) >> 1;

    fcd_cfg_shadow #(.W(W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_we),
        .num_i     (cfg_num),
        .den_i     (cfg_den),
        .stretch_i (cfg_stretch),
        .load_i    (load),
        .num_o     (act_num),
        .den_o     (act_den),
        .stretch_o (act_stretch),
        .applied_o (applied)
    );

    fcd_phase_acc #(.W(W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .running_i (running),
        .clear_i   (applied),
        .num_i     (act_num),
        .den_i     (act_den),
        .tick_o    (tick),
        .acc_o     (acc_q),
        .acc_nx_o  (acc_nx)
    );

    fcd_shape_fsm #(.W(W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .tick_i    (tick),
        .stretch_i (act_stretch),
        .acc_nx_i  (acc_nx),
        .half_i    (half),
        .state_o   (state_q),
        .clk_o     (clk_q),
        .en_o      (en_q)
    );

    assign div_en  = cfg_bypass | en_q;
    assign div_clk = cfg_bypass ? clk : clk_q;
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_run,
    input fcd_pkg::fcd_state_e state_q,
    input logic                tick,
    input logic                en_q,
    input logic                clk_q,
    input logic                act_stretch,
    input logic [W-1:0]        act_num,
    input logic [W-1:0]        act_den,
    input logic [W:0]          acc_q
);
    import fcd_pkg::*;

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> (!en_q && !clk_q));

    p_same_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !act_stretch |-> (clk_q == en_q));

    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FCD_IDLE && act_num != '0) |-> (acc_q < {1'b0, act_den}));

    p_full_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FCD_IDLE && cfg_run && act_num != '0 && act_num == act_den) |=> en_q);

    p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FCD_IDLE && !tick) |=> ($stable(act_num) && $stable(act_den)));
endmodule

bind frac_clk_div frac_clk_div_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_run     (cfg_run),
    .state_q     (state_q),
    .tick        (tick),
    .en_q        (en_q),
    .clk_q       (clk_q),
    .act_stretch (act_stretch),
    .act_num     (act_num),
    .act_den     (act_den),
    .acc_q       (acc_q)
);

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [W-1:0] cfg_num = '0;
    logic [W-1:0] cfg_den = '0;
    logic         cfg_stretch = 1'b0;
    logic         cfg_run = 1'b0;
    logic         cfg_bypass = 1'b0;
    logic         div_en, div_clk;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    int gap_cnt = 0;
    int pulse_total = 0;
    bit shape_chk = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frac_clk_div #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_num(cfg_num),
        .cfg_den(cfg_den), .cfg_stretch(cfg_stretch), .cfg_run(cfg_run),
        .cfg_bypass(cfg_bypass), .div_en(div_en), .div_clk(div_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: measures gaps between enable pulses and compares against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            gap_cnt++;
            if (shape_chk && !cfg_bypass)
                check(div_clk == div_en, "R6 clk equals enable", int'(div_clk), int'(div_en));
            if (div_en) begin
                pulse_total++;
                if (exp_q.size() != 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(gap_cnt == e, "R2/R8 pulse gap", gap_cnt, e);
                end
                gap_cnt = 0;
            end
        end
    end

    // Driver: pushes expected gaps computed from the N/M formula.
    task automatic push_gaps(input int n, input int m, input int count);
        int prev = 0;
        for (int j = 1; j <= count; j++) begin
            int t;
            t = (j * m + n - 1) / n - 1;
            exp_q.push_back((j == 1) ? t + 3 : t - prev);
            prev = t;
        end
    endtask

    task automatic write_cfg(input int n, input int m, input bit st);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_num = W'(n); cfg_den = W'(m); cfg_stretch = st;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic start_run();
        @(posedge clk); #1;
        cfg_run = 1'b1;
        gap_cnt = 0;
    endtask

    task automatic stop_run();
        @(posedge clk); #1;
        cfg_run = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(!div_en, req, int'(div_en), 0);
            check(!div_clk, req, int'(div_clk), 0);
        end
    endtask

    task automatic measure_stretch(input int n, input int m, input int hi_exp, input int lo_exp);
        int hi = 0;
        int lo = 0;
        write_cfg(n, m, 1'b1);
        start_run();
        @(negedge clk);
        while (!div_clk) @(negedge clk);
        while (div_clk) begin hi++; @(negedge clk); end
        while (!div_clk) begin lo++; @(negedge clk); end
        check(hi == hi_exp, "R7 stretched high length", hi, hi_exp);
        check(lo == lo_exp, "R7 stretched low length", lo, lo_exp);
        stop_run();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, idle outputs low
        expect_quiet(5, "R1 reset outputs");

        // R2 and R6 at 1/8, then R8 mid-run rewrite to 1/2
        shape_chk = 1'b1;
        write_cfg(1, 8, 1'b0);
        start_run();
        push_gaps(1, 8, 3);
        drain();
        exp_q.push_back(8); exp_q.push_back(2); exp_q.push_back(2);
        write_cfg(1, 2, 1'b0);
        drain();
        stop_run();

        // R2 at 3/7, then R3 long-window average
        write_cfg(3, 7, 1'b0);
        start_run();
        push_gaps(3, 7, 6);
        drain();
        begin
            int base;
            int d;
            base = pulse_total;
            repeat (700) @(negedge clk);
            d = pulse_total - base;
            check(d >= 299 && d <= 301, "R3 average ratio 3/7", d, 300);
        end
        stop_run();

        // R4 full rate
        write_cfg(5, 5, 1'b0);
        start_run();
        push_gaps(5, 5, 5);
        drain();
        stop_run();

        // R9 clamp: 9/4 behaves as 4/4
        write_cfg(9, 4, 1'b0);
        start_run();
        push_gaps(4, 4, 4);
        drain();
        stop_run();

        // R5: zero numerator, then run enable dropped while counting
        write_cfg(0, 5, 1'b0);
        start_run();
        expect_quiet(30, "R5 zero numerator");
        stop_run();
        write_cfg(1, 2, 1'b0);
        start_run();
        repeat (10) @(posedge clk);
        #1 cfg_run = 1'b0;
        @(posedge clk);
        expect_quiet(20, "R5 run cleared");
        shape_chk = 1'b0;

        // R7 stretch shapes
        measure_stretch(1, 8, 4, 4);
        measure_stretch(1, 5, 3, 2);

        // R10 bypass
        @(posedge clk); #1 cfg_bypass = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(div_en == 1'b1, "R10 bypass enable", int'(div_en), 1);
            check(div_clk == 1'b0, "R10 bypass clock low phase", int'(div_clk), 0);
            @(posedge clk); #2;
            check(div_clk == 1'b1, "R10 bypass clock high phase", int'(div_clk), 1);
        end
        cfg_bypass = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule